// File: doc/BRIEF.md
# Masked Byte-Match Interrupt Controller

This block sits beside a receive path that delivers one byte per time slot, each tagged with its channel number and a valid strobe. Two independent watchers each follow one programmable channel. Every time a byte arrives in its channel, a watcher stores the byte in its capture register. It then decides whether to flag an interrupt, by the rule its control register selects.

In equality mode, a watcher flags when the arriving byte equals its pattern register on every bit that its mask register enables. In change mode, it flags when the arriving byte differs from the byte it captured last time on any enabled bit. The interrupt line is high while either watcher has a flag pending. A processor pulses the acknowledge input and receives a one-cycle vector byte. That byte carries a fixed upper field and a low bit that names the watcher. Reading a watcher's capture register also clears its flag. Framing and serial timing lie outside the block.

Top module: `byte_match_irq`

## Requirements
- R1: After reset, irq and vec_valid are 0 and the status register reads 0. In each watcher the control, pattern and capture registers read 0x00 and the mask register reads 0xFF.
- R2: Address map, with watcher s at base 4*s: +0 control, +1 pattern, +2 mask, +3 capture (read-only); address 8 is status, with bit s holding watcher s's pending flag. A byte with rx_valid high on the channel held in control[CH_W-1:0] is stored in the capture register at that clock edge. Bytes on other channels leave the register unchanged.
- R3: With control bit 7 at 0 (equality mode), a captured byte sets the pending flag when (byte XOR pattern) AND mask is zero.
- R4: Mask bits at 0 exclude those byte bits from the comparison in both modes. A difference confined to them neither sets nor blocks a flag.
- R5: With control bit 7 at 1 (change mode), a captured byte sets the pending flag when (byte XOR previous capture) AND mask is nonzero; an unchanged byte does not.
- R6: irq is high exactly while at least one pending flag is set, and a flag becomes visible on irq one clock after the byte edge.
- R7: An iack pulse while flags are pending produces, at the next edge, vec_valid high for one cycle and vec_out = {VEC_HI, id}. Here id is the lowest-numbered pending watcher (watcher 0 first), and that watcher's flag is cleared.
- R8: iack with no flag pending produces no vector (vec_valid stays 0).
- R9: A register-bus read of a watcher's capture register clears that watcher's pending flag.
- R10: Further qualifying bytes while a flag is pending do not stack: a single acknowledge clears the flag, and a second acknowledge returns no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on capture reads) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| rx_valid | input | 1 | Received byte strobe |
| rx_chan | input | CH_W | Channel number of received byte |
| rx_byte | input | 8 | Received byte |
| irq | output | 1 | Interrupt request |
| iack | input | 1 | Interrupt acknowledge pulse |
| vec_valid | output | 1 | Vector byte valid, one cycle |
| vec_out | output | 8 | Vector byte |

## Verification
The bench builds the block with NUM_CH = 24 and VEC_HI = 7'h21, so the two vectors are 0x42 and 0x43 and are distinct from any reset or register value. With 24 channels, the channel field is 5 bits wide but not fully decoded. Watcher 1 is placed on channel 23, the highest slot, while watcher 0 sits on channel 3. This exercises the top of the channel range and a case where both watchers are pending at once, which decides the acknowledge order.

// File: rtl/bmi_pkg.sv
// Package: shared constants and register offsets for the byte-match
// interrupt controller. Assumes an 8-bit byte and exactly two watchers.
package bmi_pkg;
    localparam int DATA_W = 8;
    localparam int NSRC   = 2;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int OFS_W  = 2;
    localparam int ADDR_W = 4;
    localparam int MODE_BIT = 7;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'h8;

    typedef enum logic [OFS_W-1:0] {
        OFS_CTRL  = 2'd0,
        OFS_PAT   = 2'd1,
        OFS_MASK  = 2'd2,
        OFS_CAP   = 2'd3
    } reg_ofs_e;
endpackage

// File: rtl/bmi_masked_cmp.sv
// Module: bmi_masked_cmp
// Compares two bytes on the bit positions enabled by a mask.
// Assumes a mask bit of 1 means "compare this bit". Purely combinational.
module bmi_masked_cmp
    import bmi_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] mask,
    output logic              same
);
    logic [DATA_W-1:0] diff;

    // Per-bit difference restricted to enabled positions.
    always_comb begin
        diff = (a ^ b) & mask;
        same = (diff == '0);
    end
endmodule

// File: rtl/bmi_source.sv
// Module: bmi_source
// One watcher: holds its control, pattern, mask and capture registers,
// captures bytes of its channel and keeps a single pending flag.
// Assumes register writes arrive already decoded to this watcher and that
// a clear and a new event in the same cycle leave the flag set.
module bmi_source
    import bmi_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cap_rd,
    input  logic              ack_clr,
    input  logic              rx_valid,
    input  logic [CH_W-1:0]   rx_chan,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] pat_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] cap_q,
    output logic              pend_q
);
    logic hit;
    logic eq_pat;
    logic eq_prev;
    logic chg_mode;
    logic evt;
    logic clr;

    bmi_masked_cmp u_cmp_pat (
        .a    (rx_byte),
        .b    (pat_q),
        .mask (mask_q),
        .same (eq_pat)
    );

    bmi_masked_cmp u_cmp_prev (
        .a    (rx_byte),
        .b    (cap_q),
        .mask (mask_q),
        .same (eq_prev)
    );

    // Decide whether this cycle's byte belongs to us and qualifies.
    always_comb begin
        chg_mode = ctrl_q[MODE_BIT];
        hit      = rx_valid && (rx_chan == ctrl_q[CH_W-1:0]);
        evt      = hit && (chg_mode ? !eq_prev : eq_pat);
        clr      = ack_clr || cap_rd;
    end

    // Configuration registers written from the register bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pat_q  <= '0;
            mask_q <= '1;
        end else if (wr_en) begin
            case (wr_ofs)
                OFS_CTRL: ctrl_q <= wr_data;
                OFS_PAT:  pat_q  <= wr_data;
                OFS_MASK: mask_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // Capture register follows every byte of the selected channel.
    always_ff @(posedge clk) begin
        if (!rst_n)   cap_q <= '0;
        else if (hit) cap_q <= rx_byte;
    end

    // Pending flag: set by an event, cleared by acknowledge or capture read.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend_q <= 1'b0;
        else if (evt) pend_q <= 1'b1;
        else if (clr) pend_q <= 1'b0;
    end

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cap_q == $past(rx_byte)); // R2
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cap_q)); // R2
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend_q); // R10
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !pend_q); // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !rx_valid) |=> !pend_q); // R3
endmodule

// File: rtl/bmi_vector.sv
// Module: bmi_vector
// Acknowledge arbiter: on iack picks the lowest-numbered pending watcher,
// clears it and registers the vector byte for one cycle.
// Assumes iack is a single-cycle pulse per acknowledge cycle.
module bmi_vector
    import bmi_pkg::*;
#(
    parameter logic [DATA_W-SRC_W-1:0] VEC_HI = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iack,
    input  logic [NSRC-1:0]   pend,
    output logic [NSRC-1:0]   grant,
    output logic              vec_valid,
    output logic [DATA_W-1:0] vec_out
);
    logic [SRC_W-1:0] win_id;
    logic             any;

    // Lowest index wins; grant is one-hot while acknowledging.
    always_comb begin
        win_id = '0;
        any    = 1'b0;
        grant  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win_id = SRC_W'(i);
                any    = 1'b1;
            end
        end
        if (iack && any) grant[win_id] = 1'b1;
    end

    // Vector byte register, valid for the cycle after the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= iack && any;
            if (iack && any) vec_out <= {VEC_HI, win_id};
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R7
    AST_VEC_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(iack)); // R8
    AST_IDLE_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && pend == '0) |=> !vec_valid); // R8
    AST_PRIO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && pend[0]) |=> vec_out[SRC_W-1:0] == '0); // R7
endmodule

// File: rtl/byte_match_irq.sv
// Module: byte_match_irq (top)
// Two channel watchers with masked equality or change detection, a
// register bus for configuration and status, and an auto-vectored
// acknowledge. Assumes one received byte per cycle at most and a
// synchronous, active-low reset.
module byte_match_irq
    import bmi_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter logic [DATA_W-SRC_W-1:0] VEC_HI = 7'h5A,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_valid,
    input  logic [CH_W-1:0]   rx_chan,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              irq,
    input  logic              iack,
    output logic              vec_valid,
    output logic [DATA_W-1:0] vec_out
);
    localparam int SEL_W = ADDR_W - OFS_W;

    logic [NSRC-1:0]   pend;
    logic [NSRC-1:0]   grant;
    logic [DATA_W-1:0] ctrl_r [NSRC];
    logic [DATA_W-1:0] pat_r  [NSRC];
    logic [DATA_W-1:0] mask_r [NSRC];
    logic [DATA_W-1:0] cap_r  [NSRC];
    logic [SEL_W-1:0]  sel;
    logic [OFS_W-1:0]  ofs;

    // Split the register address into watcher select and offset.
    always_comb begin
        sel = reg_addr[ADDR_W-1:OFS_W];
        ofs = reg_addr[OFS_W-1:0];
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic wr_s;
        logic rd_cap_s;

        // Per-watcher write and capture-read decode.
        always_comb begin
            wr_s     = reg_wr && (sel == SEL_W'(s));
            rd_cap_s = reg_rd && (sel == SEL_W'(s)) && (ofs == OFS_CAP);
        end

        bmi_source #(.NUM_CH(NUM_CH)) u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_s),
            .wr_ofs   (ofs),
            .wr_data  (reg_wdata),
            .cap_rd   (rd_cap_s),
            .ack_clr  (grant[s]),
            .rx_valid (rx_valid),
            .rx_chan  (rx_chan),
            .rx_byte  (rx_byte),
            .ctrl_q   (ctrl_r[s]),
            .pat_q    (pat_r[s]),
            .mask_q   (mask_r[s]),
            .cap_q    (cap_r[s]),
            .pend_q   (pend[s])
        );
    end

    bmi_vector #(.VEC_HI(VEC_HI)) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .iack      (iack),
        .pend      (pend),
        .grant     (grant),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    // Interrupt line is the OR of the pending flags.
    always_comb irq = |pend;

    // Read data multiplexer over watcher registers and status.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_STATUS) begin
            reg_rdata[NSRC-1:0] = pend;
        end else begin
            for (int s = 0; s < NSRC; s++) begin
                if (sel == SEL_W'(s)) begin
                    case (ofs)
                        OFS_CTRL: reg_rdata = ctrl_r[s];
                        OFS_PAT:  reg_rdata = pat_r[s];
                        OFS_MASK: reg_rdata = mask_r[s];
                        default:  reg_rdata = cap_r[s];
                    endcase
                end
            end
        end
    end

    AST_IRQ_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(rx_valid)); // R6
    AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !$past(iack, 1)) |-> 1'b0); // R7
    AST_IRQ_WITH_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && !irq) |=> !vec_valid); // R8
endmodule

// File: tb/byte_match_irq_test.sv
// Bench: table-driven equality-mode sweep, then directed tests.
module byte_match_irq_test;
    localparam int NUM_CH = 24;
    localparam int CH_W = $clog2(NUM_CH);
    localparam logic [6:0] VHI = 7'h21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_valid = 1'b0;
    logic [CH_W-1:0] rx_chan = '0;
    logic [7:0] rx_byte = '0;
    logic       irq, iack = 1'b0, vec_valid;
    logic [7:0] vec_out;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    byte_match_irq #(.NUM_CH(NUM_CH), .VEC_HI(VHI)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_byte(rx_byte),
        .irq(irq), .iack(iack), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    // {pattern, mask, byte, expected flag} for watcher 0 in equality mode
    localparam logic [24:0] TBL [8] = '{
        {8'hA5, 8'hFF, 8'hA5, 1'b1},
        {8'hA5, 8'hFF, 8'hA4, 1'b0},
        {8'hA5, 8'hF0, 8'hAF, 1'b1},
        {8'hA5, 8'h0F, 8'h35, 1'b1},
        {8'hA5, 8'h0F, 8'h36, 1'b0},
        {8'h00, 8'h00, 8'h77, 1'b1},
        {8'hFF, 8'h80, 8'h7F, 1'b0},
        {8'h3C, 8'h3C, 8'hFC, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic send(input int ch, input logic [7:0] b);
        @(negedge clk); rx_chan = CH_W'(ch); rx_byte = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic ack(output logic v, output logic [7:0] o);
        @(negedge clk); iack = 1'b1;
        @(negedge clk); iack = 1'b0; v = vec_valid; o = vec_out;
    endtask

    initial begin
        logic [7:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 vec_valid", vec_valid, 0);
        rd(4'h8, d); chk("R1 status", d, 0);
        rd(4'h0, d); chk("R1 ctrl0", d, 0);
        rd(4'h2, d); chk("R1 mask0", d, 8'hFF);
        rd(4'h7, d); chk("R1 cap1", d, 0);

        // R3/R4 table sweep on watcher 0, channel 3
        wr(4'h0, 8'h03);
        for (int i = 0; i < 8; i++) begin
            wr(4'h1, TBL[i][24:17]);
            wr(4'h2, TBL[i][16:9]);
            send(3, TBL[i][8:1]);
            chk("R3 R4 flag", irq, TBL[i][0]);
            rd(4'h3, d); chk("R2 capture", d, TBL[i][8:1]);
            chk("R9 read clears", irq, 0);
        end

        // R2 other channel leaves capture unchanged
        send(4, 8'h55);
        rd(4'h3, d); chk("R2 other chan", d, 8'hFC);

        // R5 change mode on watcher 1, channel 23
        wr(4'h4, 8'h80 | 8'd23);
        send(23, 8'h10);
        chk("R5 change flags", irq, 1);
        rd(4'h8, d); chk("R6 status", d, 2);
        rd(4'h7, d); chk("R9 cap1 clear", irq, 0);
        send(23, 8'h10);
        chk("R5 unchanged", irq, 0);
        wr(4'h6, 8'h0F);
        send(23, 8'h90);
        chk("R4 masked change", irq, 0);
        send(23, 8'h91);
        chk("R5 unmasked change", irq, 1);

        // R7 both pending: watcher 0 first
        wr(4'h1, 8'h11); wr(4'h2, 8'hFF);
        send(3, 8'h11);
        rd(4'h8, d); chk("R6 both", d, 3);
        ack(v, d); chk("R7 valid", v, 1); chk("R7 vec0", d, {VHI, 1'b0});
        @(negedge clk); chk("R7 one cycle", vec_valid, 0);
        chk("R6 irq still", irq, 1);
        ack(v, d); chk("R7 vec1", d, {VHI, 1'b1});
        chk("R6 irq low", irq, 0);
        ack(v, d); chk("R8 no vector", v, 0);

        // R10 repeated matches do not stack
        send(3, 8'h11); send(3, 8'h11);
        ack(v, d); chk("R10 vec", d, {VHI, 1'b0});
        chk("R10 irq low", irq, 0);
        ack(v, d); chk("R10 no second", v, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule